// File: doc/BRIEF.md
# Variable-Length Serial Register Port

This block is a serial slave that lets an external master read and write a bank of ten configuration registers of differing widths. The master lowers a chip select and clocks in an instruction byte that carries a read/write flag and a 5-bit register address. A data phase follows whose length equals the width of the addressed register. On a write, the bits are gathered into a staging buffer and committed to the register in one step after the last bit. On a read, the register is shifted out one bit per serial clock.

Two bits of register 0 set the port's own behaviour. One selects the bit order. The other selects whether read data returns on the shared data pin or on a separate output pin. Raising chip select pauses a transfer, and lowering it again resumes the transfer where it stopped. A separate I/O reset input aborts the transfer. All serial inputs are brought into a faster system clock domain through two-flop synchronisers, and serial clock edges are found by comparing successive samples.

The controller has three states. `ST_INSTR` collects the instruction byte. `ST_WDATA` collects write data. `ST_RDATA` shifts out read data. The transitions are:
- instruction-complete with the read flag clear: `ST_INSTR` to `ST_WDATA`.
- instruction-complete with the read flag set: `ST_INSTR` to `ST_RDATA`.
- data-complete: either data state back to `ST_INSTR`.
- abort: any state to `ST_INSTR`, whenever the synchronised I/O reset is high.

Top module: `ser_reg_port`

## Requirements
- R1: The instruction byte's logical bit 7 selects read (1) or write (0). Logical bits 4..0 give the register address, and logical bits 6 and 5 are ignored.
- R2: The data phase after the instruction lasts exactly as many bits as the addressed register is wide:
  - address 0: 32 bits
  - address 1: 40 bits
  - addresses 2 and 3: 24 bits
  - addresses 4 and 5: 16 bits
  - addresses 6 to 9: 64 bits
  - any other address: 8 bits
- R3: After reset every register is zero except register 1, which holds 0x0000780007. Unused bits always read as zero:
  - register 0: bits 31..25 and 13..8
  - register 1: bits 38..34 and 7..6
  - registers 6 to 9: bits 63..62
- R4: Register 0 bit 15 selects the bit order, with 1 meaning least significant bit first and 0 meaning most significant bit first (the reset default). The selected order applies to the instruction byte and to the data. A change takes effect from the next instruction byte.
- R5: Register 0 bit 14 selects the read pin. When it is 0, read data is driven on the shared data pin and the separate output pin stays undriven. When it is 1, only the separate output pin is driven. The two pins are never driven together.
- R6: While chip select is high, neither data pin is driven and the transfer is frozen. When chip select returns low, the transfer continues from the next bit.
- R7: A high I/O reset aborts the current transfer and returns the port to waiting for an instruction byte. It leaves every register unchanged.
- R8: A write changes the target register only after its final data bit arrives. A partial write leaves the register unchanged.
- R9: Addresses above 9 are accepted. Writes to them change nothing, and reads from them return zeros.
- R10: Input bits are sampled on serial clock rising edges. Read data changes after falling edges, so the first read bit is valid before the first data-phase rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip select |
| io_rst | input | 1 | Active-high transfer abort |
| sdio_in | input | 1 | Serial data into the port |
| sdio_out | output | 1 | Read data for the shared data pin |
| sdio_oe | output | 1 | Output enable of the shared data pin |
| sdo_out | output | 1 | Read data for the separate output pin |
| sdo_oe | output | 1 | Output enable of the separate output pin |
| cfg_main | output | 32 | Register 0 contents |
| cfg_clk | output | 40 | Register 1 contents |
| step_up | output | 24 | Register 2 contents |
| step_dn | output | 24 | Register 3 contents |
| rate_up | output | 16 | Register 4 contents |
| rate_dn | output | 16 | Register 5 contents |
| profiles | output | 256 | Registers 6..9, register 6+k at bits 64k+63..64k |

## Verification
Writes are exercised at every register width, with all-ones patterns that expose the unused-bit masks and with mixed patterns that expose bit reversal. Reads are exercised in both bit orders and on both pins. Switching register 0 between orders shows whether the order change lands exactly at the next instruction byte. Pauses during both a write and a read separate a true freeze from a restart. An I/O reset in the middle of a write and an access to an unlisted address separate discarding a transfer from committing a partial one.

// File: rtl/ser_pkg.sv
package ser_pkg;
    localparam int ADDR_W = 5;
    localparam int WORD_W = 64;
    localparam int CNT_W  = 7;
    localparam int NREG   = 10;

    typedef enum logic [1:0] {ST_INSTR, ST_WDATA, ST_RDATA} st_t;

    function automatic logic [CNT_W-1:0] reg_width(input logic [ADDR_W-1:0] a);
        case (a)
            5'd0:                   reg_width = 7'd32;
            5'd1:                   reg_width = 7'd40;
            5'd2, 5'd3:             reg_width = 7'd24;
            5'd4, 5'd5:             reg_width = 7'd16;
            5'd6, 5'd7, 5'd8, 5'd9: reg_width = 7'd64;
            default:                reg_width = 7'd8;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] reg_mask(input int idx);
        case (idx)
            0:       reg_mask = 64'h0000_0000_01FF_C0FF;
            1:       reg_mask = 64'h0000_0083_FFFF_FF3F;
            2, 3:    reg_mask = 64'h0000_0000_00FF_FFFF;
            4, 5:    reg_mask = 64'h0000_0000_0000_FFFF;
            default: reg_mask = 64'h3FFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] reg_init(input int idx);
        reg_init = (idx == 1) ? 64'h0000_0000_0078_0007 : '0;
    endfunction
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
    parameter int         W   = 4,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta      <= RST[g];
                q[g]      <= RST[g];
                q_prev[g] <= RST[g];
            end else begin
                meta      <= d[g];
                q[g]      <= meta;
                q_prev[g] <= q[g];
            end
        end
    end
endmodule

// File: rtl/ser_regbank.sv
module ser_regbank
    import ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata,
    output logic [WORD_W*NREG-1:0] all_q
);
    logic [WORD_W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[g] <= reg_init(g);
            else if (we && (waddr == ADDR_W'(g)))
                regs[g] <= wdata & reg_mask(g);
        end
        assign all_q[g*WORD_W +: WORD_W] = regs[g];
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++)
            if (raddr == ADDR_W'(i)) rdata = regs[i];
    end

    // R8: register contents move only on a commit strobe
    a_r8_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(all_q));
endmodule

// File: rtl/ser_reg_port.sv
module ser_reg_port
    import ser_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk,
    input  logic         cs_n,
    input  logic         io_rst,
    input  logic         sdio_in,
    output logic         sdio_out,
    output logic         sdio_oe,
    output logic         sdo_out,
    output logic         sdo_oe,
    output logic [31:0]  cfg_main,
    output logic [39:0]  cfg_clk,
    output logic [23:0]  step_up,
    output logic [23:0]  step_dn,
    output logic [15:0]  rate_up,
    output logic [15:0]  rate_dn,
    output logic [255:0] profiles
);
    localparam int LSB_BIT  = 15;
    localparam int PIN_BIT  = 14;
    localparam int INSTR_W  = 8;

    logic [3:0] s_now, s_prev;
    ser_sync #(.W(4), .RST(4'b0010)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({io_rst, sdio_in, cs_n, sclk}),
        .q(s_now), .q_prev(s_prev)
    );

    logic cs_s, din_s, iorst_s, rise, fall;
    assign cs_s    = s_now[1];
    assign din_s   = s_now[2];
    assign iorst_s = s_now[3];
    assign rise    = s_now[0] & ~s_prev[0] & ~cs_s;
    assign fall    = ~s_now[0] & s_prev[0] & ~cs_s;

    st_t                 state, state_n;
    logic [CNT_W-1:0]    cnt, width_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [INSTR_W-1:0]  instr, instr_full;
    logic [WORD_W-1:0]   wbuf, wbuf_full, rdata;
    logic [WORD_W*NREG-1:0] all_q;
    logic                lsb_q, four_q, sout, last_bit, we;
    logic [2:0]          ipos;
    logic [5:0]          pos;

    assign ipos     = lsb_q ? cnt[2:0] : 3'd7 - cnt[2:0];
    assign pos      = lsb_q ? cnt[5:0] : width_q[5:0] - 6'd1 - cnt[5:0];
    assign last_bit = (cnt == width_q - 7'd1);

    always_comb begin
        instr_full       = instr;
        instr_full[ipos] = din_s;
        wbuf_full        = wbuf;
        wbuf_full[pos]   = din_s;
    end

    always_comb begin
        state_n = state;
        if (iorst_s)
            state_n = ST_INSTR;
        else if (rise) begin
            unique case (state)
                ST_INSTR: if (cnt == 7'd7) state_n = instr_full[7] ? ST_RDATA : ST_WDATA;
                ST_WDATA: if (last_bit) state_n = ST_INSTR;
                ST_RDATA: if (last_bit) state_n = ST_INSTR;
                default:  state_n = ST_INSTR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_INSTR;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            width_q <= 7'd8;
            addr_q  <= '0;
            instr   <= '0;
            wbuf    <= '0;
            lsb_q   <= 1'b0;
            four_q  <= 1'b0;
            sout    <= 1'b0;
        end else if (iorst_s) begin
            cnt  <= '0;
            sout <= 1'b0;
        end else begin
            if (state == ST_INSTR && cnt == '0) begin
                lsb_q  <= cfg_main[LSB_BIT];
                four_q <= cfg_main[PIN_BIT];
            end
            if (rise) begin
                unique case (state)
                    ST_INSTR: begin
                        instr <= instr_full;
                        if (cnt == 7'd7) begin
                            cnt     <= '0;
                            addr_q  <= instr_full[4:0];
                            width_q <= reg_width(instr_full[4:0]);
                            wbuf    <= '0;
                        end else
                            cnt <= cnt + 7'd1;
                    end
                    ST_WDATA: begin
                        wbuf <= wbuf_full;
                        cnt  <= last_bit ? '0 : cnt + 7'd1;
                    end
                    ST_RDATA: cnt <= last_bit ? '0 : cnt + 7'd1;
                    default:  cnt <= '0;
                endcase
            end
            if (fall && state == ST_RDATA)
                sout <= rdata[pos];
        end
    end

    assign we = rise && !iorst_s && state == ST_WDATA && last_bit;

    ser_regbank u_bank (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(addr_q), .wdata(wbuf_full),
        .raddr(addr_q), .rdata(rdata), .all_q(all_q)
    );

    assign cfg_main = all_q[31:0];
    assign cfg_clk  = all_q[64 +: 40];
    assign step_up  = all_q[128 +: 24];
    assign step_dn  = all_q[192 +: 24];
    assign rate_up  = all_q[256 +: 16];
    assign rate_dn  = all_q[320 +: 16];
    assign profiles = all_q[384 +: 256];

    always_comb begin
        sdio_out = sout;
        sdo_out  = sout;
        sdio_oe  = (state == ST_RDATA) && !cs_s && !four_q;
        sdo_oe   = (state == ST_RDATA) && !cs_s && four_q;
    end

    a_r5_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
        !(sdio_oe && sdo_oe));
    a_r6_frozen_while_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && !iorst_s) |=> ($stable(cnt) && $stable(state)));
    a_r7_abort_to_instr: assert property (@(posedge clk) disable iff (!rst_n)
        iorst_s |=> (state == ST_INSTR && cnt == '0));
    a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_INSTR) |-> (cnt < width_q));
    a_r4_order_held_mid_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_INSTR || cnt != '0) |=> ($stable(lsb_q) && $stable(four_q)));
endmodule

// File: tb/test_ser_reg_port.sv
module test_ser_reg_port;
    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, io_rst = 1'b0, sdio_in = 1'b0;
    logic sdio_out, sdio_oe, sdo_out, sdo_oe;
    logic [31:0] cfg_main; logic [39:0] cfg_clk;
    logic [23:0] step_up, step_dn; logic [15:0] rate_up, rate_dn;
    logic [255:0] profiles;

    int checks = 0, errors = 0;
    logic cmp_en = 1'b0, b_lsb = 1'b0, b_four = 1'b0;
    logic [63:0] m [10];

    always #4 clk = ~clk;

    ser_reg_port i_ser_reg_port (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .io_rst(io_rst),
        .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe),
        .sdo_out(sdo_out), .sdo_oe(sdo_oe), .cfg_main(cfg_main), .cfg_clk(cfg_clk),
        .step_up(step_up), .step_dn(step_dn), .rate_up(rate_up), .rate_dn(rate_dn),
        .profiles(profiles)
    );

    function automatic int bw(input logic [4:0] a);
        if (a == 0) return 32; if (a == 1) return 40;
        if (a < 4) return 24;  if (a < 6) return 16;
        if (a < 10) return 64; return 8;
    endfunction

    function automatic logic [63:0] bmask(input int a);
        logic [63:0] k = '1;
        if (a == 0) begin k = 64'hFFFF_FFFF; k[31:25] = '0; k[13:8] = '0; end
        else if (a == 1) begin k = 64'hFF_FFFF_FFFF; k[38:34] = '0; k[7:6] = '0; end
        else if (a < 4) k = 64'hFF_FFFF;
        else if (a < 6) k = 64'hFFFF;
        else k[63:62] = '0;
        return k;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    // R3 / R8: register outputs compared against the model on every clock while idle
    always @(negedge clk) begin
        if (cmp_en) begin
            chk({cfg_main, cfg_clk, step_up, step_dn, rate_up, rate_dn} ==
                {m[0][31:0], m[1][39:0], m[2][23:0], m[3][23:0], m[4][15:0], m[5][15:0]},
                "R3/R8 regs 0-5", {cfg_main, step_up[7:0]}, {m[0][31:0], m[2][7:0]});
            chk(profiles == {m[9], m[8], m[7], m[6]}, "R3/R8 profiles", profiles[63:0], m[6]);
            chk(!sdio_oe && !sdo_oe, "R6 idle pins undriven", {sdio_oe, sdo_oe}, 0);
        end
        if (rst_n) chk(!(sdio_oe && sdo_oe), "R5 one driver", {sdio_oe, sdo_oe}, 1);
    end

    task automatic clks(input int n); repeat (n) @(posedge clk); endtask

    task automatic bit_out(input logic b);
        sclk = 1'b0; sdio_in = b; clks(6);
        sclk = 1'b1; clks(6);
    endtask

    task automatic open_t; cmp_en = 1'b0; cs_n = 1'b0; clks(4); endtask

    task automatic close_t;
        cs_n = 1'b1; clks(2); sclk = 1'b0; clks(8);
        b_lsb = m[0][15]; b_four = m[0][14];   // R4: order applies from next instruction
        cmp_en = 1'b1; clks(2);
    endtask

    task automatic send(input logic [63:0] v, input int n, input int pause_at);
        for (int i = 0; i < n; i++) begin
            if (i == pause_at) begin
                cs_n = 1'b1; clks(30); cs_n = 1'b0; clks(4);
            end
            bit_out(b_lsb ? v[i] : v[n-1-i]);
        end
    endtask

    // R1: instruction = {rw, two ignored bits, 5-bit address}
    task automatic wr(input logic [4:0] a, input logic [63:0] v, input logic [1:0] junk, input int pause_at);
        open_t;
        send({56'd0, 1'b0, junk, a}, 8, -1);
        send(v, bw(a), pause_at);
        if (a < 10) m[a] = v & bmask(a);   // R9: others discarded
        close_t;
    endtask

    task automatic rd(input logic [4:0] a, input logic [63:0] exp, input int pause_at, input string req);
        logic [63:0] got = '0;
        bit wrong = 0, hiz_bad = 0;
        int n = bw(a);
        open_t;
        send({56'd0, 1'b1, 2'b00, a}, 8, -1);
        for (int i = 0; i < n; i++) begin
            if (i == pause_at) begin
                cs_n = 1'b1; clks(10);
                if (sdio_oe || sdo_oe) hiz_bad = 1;   // R6
                clks(20); cs_n = 1'b0; clks(4);
            end
            sclk = 1'b0; clks(6);               // R10: data valid after the falling edge
            if (b_four) begin got[b_lsb ? i : n-1-i] = sdo_out; if (sdio_oe || !sdo_oe) wrong = 1; end
            else begin got[b_lsb ? i : n-1-i] = sdio_out; if (sdo_oe || !sdio_oe) wrong = 1; end
            sclk = 1'b1; clks(6);
        end
        chk(got == exp, req, got, exp);
        chk(!wrong, "R5 read pin selection", {63'd0, wrong}, 0);
        if (pause_at >= 0) chk(!hiz_bad, "R6 pins undriven during pause", {63'd0, hiz_bad}, 0);
        close_t;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired got=hang expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 10; i++) m[i] = '0;
        m[1] = 64'h78_0007;
        clks(3); rst_n = 1'b1; clks(4);
        cmp_en = 1'b1; clks(4);                           // R3 reset state
        chk(cfg_clk == 40'h00_0078_0007, "R3 reg1 reset", {24'd0, cfg_clk}, 64'h78_0007);

        wr(5'd2, 64'h12_3456, 2'b00, -1);                // R2 24-bit, MSB first
        wr(5'd4, 64'hBEEF, 2'b00, -1);                   // R2 16-bit
        wr(5'd6, 64'hFEDC_BA98_7654_3210, 2'b00, -1);    // R2 64-bit, R3 mask
        wr(5'd1, 64'hFF_FFFF_FFFF, 2'b00, -1);           // R3 unused bits stay zero
        wr(5'd3, 64'hA5_C3E1, 2'b11, -1);                // R1 bits 6,5 ignored
        rd(5'd1, m[1], -1, "R1 R10 read reg1 shared pin");
        rd(5'd6, m[6], -1, "R2 read reg6");

        wr(5'd9, 64'h0123_4567_89AB_CDEF, 2'b00, 20);   // R6 pause mid write
        rd(5'd2, m[2], 7, "R6 resume read reg2");

        // R7 / R8: abort a partial write to reg4
        open_t;
        send({56'd0, 8'h04}, 8, -1);
        send(64'h1111, 9, -1);
        io_rst = 1'b1; clks(8); io_rst = 1'b0; clks(6);
        close_t;
        chk(rate_up == 16'hBEEF, "R7 R8 aborted write leaves reg4", {48'd0, rate_up}, 64'hBEEF);
        wr(5'd5, 64'h5A5A, 2'b00, -1);                   // R7 port ready after abort

        wr(5'd31, 64'hFF, 2'b00, -1);                    // R9 discarded write
        rd(5'd31, 64'h0, -1, "R9 unlisted address reads zero");

        wr(5'd0, 64'h0000_8000, 2'b00, -1);              // R4 switch to LSB first
        chk(cfg_main == 32'h8000, "R4 mode write itself in old order", {32'd0, cfg_main}, 64'h8000);
        wr(5'd3, 64'h0C_1B2A, 2'b00, -1);
        rd(5'd3, 64'h0C_1B2A, -1, "R4 LSB-first read reg3");
        wr(5'd0, 64'h0000_C000, 2'b00, -1);              // R5 separate output pin
        rd(5'd5, 64'h5A5A, 4, "R5 read reg5 on separate pin");
        wr(5'd0, 64'h0000_0000, 2'b00, -1);              // back to MSB first, shared pin
        rd(5'd4, 64'hBEEF, -1, "R4 R5 back to defaults");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule